// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns an I/O virtual address issued by a DMA master into a physical page address by looking it up in a table of translation entries held in on-chip RAM. Each entry holds a physical page address in its upper bits and a two-bit access code in its lowest bits. The page size is set at run time by a shift value, and the number of live entries is set by a count. A count of zero switches translation off entirely.

A master presents an address and a direction on a valid/ready request channel. One cycle after the request is accepted, the response channel returns four values: the page-aligned input address, the page-aligned translated address, the page-offset mask, and the access code. A separate flag is raised when the request's direction is forbidden by that code. Addresses that fall outside the window give a "no access" response instead of stalling. The table is loaded through a separate write port. A configuration output reports the window size in bytes.

Top module: `tce_xlate_unit`

## Requirements
- R1: After reset `reqReady` is 1 and `rspValid` is 0. Whenever `rspValid` is 0, `rspIova`, `rspXlat`, `rspMask`, `rspPerm` and `rspFault` are all 0.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `rspValid` is 1 from the next cycle until an edge where `rspReady` is 1. While it is 1, `reqReady` is 0 and all response fields hold steady. Only one request is outstanding at a time.
- R3: The table index is the request address shifted right by `cfgPageShift`. The request is in range only when this index is below the effective count, which is min(`cfgEntryCount`, 2^IDX_W).
- R4: For an in-range request, `rspMask` is 2^shift − 1. `rspIova` is the request address with those offset bits cleared. `rspXlat` is the table entry with those offset bits cleared.
- R5: For an in-range request, `rspPerm` equals bits [1:0] of the entry. The encoding is 0 = no access, 1 = read-only, 2 = write-only, 3 = read-write.
- R6: An out-of-range request returns `rspPerm`=0, `rspXlat`=0, `rspIova`=0, `rspMask` all ones and `rspFault`=0.
- R7: `rspFault` is 1 only for an in-range request where either a write (`reqIsWrite`=1) meets code 1, or a read meets code 2. It is 0 in all other cases.
- R8: When `cfgEntryCount` is 0, every request is out of range, and `cfgWinSize` is 0.
- R9: The page shift and entry count in force are those present on the edge that accepts the request. Later changes do not alter a pending response.
- R10: A table write (`tblWrEn`) stores `tblWrData` at `tblWrIdx`. Requests accepted on a later edge see the new value. A write to an entry while a response for that entry is pending does not change that response.
- R11: `cfgWinSize` equals the effective count shifted left by `cfgPageShift`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPageShift | input | SHIFT_W | log2 of the page size |
| cfgEntryCount | input | IDX_W+1 | Number of live table entries, 0 = disabled |
| cfgWinSize | output | ADDR_W+IDX_W+1 | Window size in bytes |
| tblWrEn | input | 1 | Table write strobe |
| tblWrIdx | input | IDX_W | Table write index |
| tblWrData | input | ADDR_W | Table entry to write |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready |
| reqAddr | input | ADDR_W | I/O virtual address |
| reqIsWrite | input | 1 | 1 = write access, 0 = read |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response ready |
| rspIova | output | ADDR_W | Page-aligned input address |
| rspXlat | output | ADDR_W | Page-aligned translated address |
| rspMask | output | ADDR_W | Page-offset mask |
| rspPerm | output | 2 | Access code |
| rspFault | output | 1 | Direction not permitted by the entry |

## Verification
The bench builds the unit with ADDR_W=32 and IDX_W=4, which gives a 16-entry table. With so few entries, the clamp of an oversized count (20) to the table depth can be reached directly, and so can the index just past the last entry. Page shifts of 8, 12 and 16 are used, so the mask and the index boundaries move with the shift. The sequence that holds a response pending while the shift changes and the same entry is rewritten shows that the captured state is used, not the live state.

// File: rtl/tce_xlate_pkg.sv
package tce_xlate_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RESP = 1'b1
  } ctrl_state_e;

  typedef struct packed {
    logic capture;
    logic present;
  } ctrl_strobe_t;

endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl
  import tce_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         rspReady,
  output logic         reqReady,
  output ctrl_strobe_t strobe
);

  ctrl_state_e state, stateNxt;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strobe.capture = reqValid && reqReady;
    strobe.present = (state == ST_RESP);
    stateNxt       = state;
    case (state)
      ST_IDLE: if (strobe.capture) stateNxt = ST_RESP;
      ST_RESP: if (rspReady)       stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/tce_datapath.sv
module tce_datapath
  import tce_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int SHIFT_W = 5,
  parameter int WIN_W   = ADDR_W + IDX_W + 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [SHIFT_W-1:0] cfgPageShift,
  input  logic [IDX_W:0]     cfgEntryCount,
  output logic [WIN_W-1:0]   cfgWinSize,
  input  logic               tblWrEn,
  input  logic [IDX_W-1:0]   tblWrIdx,
  input  logic [ADDR_W-1:0]  tblWrData,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqIsWrite,
  output logic [ADDR_W-1:0]  rspIova,
  output logic [ADDR_W-1:0]  rspXlat,
  output logic [ADDR_W-1:0]  rspMask,
  output logic [1:0]         rspPerm,
  output logic               rspFault
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] DEPTH_CNT = (IDX_W+1)'(DEPTH);

  logic [ADDR_W-1:0] tblMem [DEPTH];

  logic [IDX_W:0]     effCount;
  logic [ADDR_W-1:0]  idxFull;
  logic               inRangeNow;

  logic [ADDR_W-1:0]  addrQ;
  logic [ADDR_W-1:0]  entryQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic               inRangeQ;
  logic               isWriteQ;

  logic [ADDR_W-1:0]  pageMask;
  perm_e              permNow;

  // Effective count and window size
  always_comb begin
    effCount   = (cfgEntryCount > DEPTH_CNT) ? DEPTH_CNT : cfgEntryCount;
    cfgWinSize = WIN_W'(effCount) << cfgPageShift;
    idxFull    = reqAddr >> cfgPageShift;
    inRangeNow = idxFull < ADDR_W'(effCount);
  end

  // Table storage, written by a separate port
  always_ff @(posedge clk) begin
    if (tblWrEn) tblMem[tblWrIdx] <= tblWrData;
  end

  // Synchronous read and request capture
  always_ff @(posedge clk) begin
    if (strobe.capture) entryQ <= tblMem[idxFull[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      shiftQ   <= '0;
      inRangeQ <= 1'b0;
      isWriteQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ    <= reqAddr;
      shiftQ   <= cfgPageShift;
      inRangeQ <= inRangeNow;
      isWriteQ <= reqIsWrite;
    end
  end

  // Response formation
  always_comb begin
    pageMask = ~({ADDR_W{1'b1}} << shiftQ);
    permNow  = perm_e'(entryQ[1:0]);
    rspIova  = '0;
    rspXlat  = '0;
    rspMask  = '0;
    rspPerm  = PERM_NONE;
    rspFault = 1'b0;
    if (strobe.present) begin
      if (inRangeQ) begin
        rspIova  = addrQ & ~pageMask;
        rspXlat  = entryQ & ~pageMask;
        rspMask  = pageMask;
        rspPerm  = permNow;
        rspFault = (isWriteQ && permNow == PERM_RD) ||
                   (!isWriteQ && permNow == PERM_WR);
      end else begin
        rspMask  = '1;
      end
    end
  end

endmodule

// File: rtl/tce_xlate_unit.sv
module tce_xlate_unit
  import tce_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int SHIFT_W = 5,
  parameter int WIN_W   = ADDR_W + IDX_W + 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SHIFT_W-1:0] cfgPageShift,
  input  logic [IDX_W:0]     cfgEntryCount,
  output logic [WIN_W-1:0]   cfgWinSize,
  input  logic               tblWrEn,
  input  logic [IDX_W-1:0]   tblWrIdx,
  input  logic [ADDR_W-1:0]  tblWrData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqIsWrite,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [ADDR_W-1:0]  rspIova,
  output logic [ADDR_W-1:0]  rspXlat,
  output logic [ADDR_W-1:0]  rspMask,
  output logic [1:0]         rspPerm,
  output logic               rspFault
);

  ctrl_strobe_t strobe;

  tce_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  tce_datapath #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .SHIFT_W (SHIFT_W),
    .WIN_W   (WIN_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgPageShift  (cfgPageShift),
    .cfgEntryCount (cfgEntryCount),
    .cfgWinSize    (cfgWinSize),
    .tblWrEn       (tblWrEn),
    .tblWrIdx      (tblWrIdx),
    .tblWrData     (tblWrData),
    .reqAddr       (reqAddr),
    .reqIsWrite    (reqIsWrite),
    .rspIova       (rspIova),
    .rspXlat       (rspXlat),
    .rspMask       (rspMask),
    .rspPerm       (rspPerm),
    .rspFault      (rspFault)
  );

  assign rspValid = strobe.present;

endmodule

// File: rtl/tce_xlate_chk.sv
module tce_xlate_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] rspIova,
  input logic [ADDR_W-1:0] rspXlat,
  input logic [ADDR_W-1:0] rspMask,
  input logic [1:0]        rspPerm,
  input logic              rspFault
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspXlat == '0 && rspPerm == 2'd0 && !rspFault));

  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspXlat) &&
      $stable(rspIova) && $stable(rspMask) && $stable(rspPerm)));

  // R4
  aligned_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspIova & rspMask) == '0 && (rspXlat & rspMask) == '0));

  // R6
  oob_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && &rspMask) |-> (rspPerm == 2'd0 && rspXlat == '0 && !rspFault));

  // R7
  fault_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPerm == 2'd1 || rspPerm == 2'd2));

endmodule

bind tce_xlate_unit tce_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspIova  (rspIova),
  .rspXlat  (rspXlat),
  .rspMask  (rspMask),
  .rspPerm  (rspPerm),
  .rspFault (rspFault)
);

// File: tb/sim_tce_xlate_unit.sv
module sim_tce_xlate_unit;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 4;
  localparam int SHIFT_W = 5;
  localparam int WIN_W   = ADDR_W + IDX_W + 1;
  localparam int DEPTH   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SHIFT_W-1:0] cfgPageShift = 5'd12;
  logic [IDX_W:0]     cfgEntryCount = 5'd16;
  logic [WIN_W-1:0]   cfgWinSize;
  logic               tblWrEn = 1'b0;
  logic [IDX_W-1:0]   tblWrIdx = '0;
  logic [ADDR_W-1:0]  tblWrData = '0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic               reqIsWrite = 1'b0;
  logic               rspValid;
  logic               rspReady = 1'b0;
  logic [ADDR_W-1:0]  rspIova, rspXlat, rspMask;
  logic [1:0]         rspPerm;
  logic               rspFault;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] shadow [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tce_xlate_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgPageShift(cfgPageShift),
    .cfgEntryCount(cfgEntryCount), .cfgWinSize(cfgWinSize),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrData(tblWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqIsWrite(reqIsWrite), .rspValid(rspValid), .rspReady(rspReady),
    .rspIova(rspIova), .rspXlat(rspXlat), .rspMask(rspMask),
    .rspPerm(rspPerm), .rspFault(rspFault)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [ADDR_W-1:0] val);
    tblWrEn = 1'b1; tblWrIdx = IDX_W'(idx); tblWrData = val;
    @(posedge clk); @(negedge clk);
    tblWrEn = 1'b0;
    shadow[idx] = val;
  endtask

  // Independent model of a response
  task automatic model(input logic [ADDR_W-1:0] addr, input bit isWr,
                       output logic [ADDR_W-1:0] eIova, output logic [ADDR_W-1:0] eXlat,
                       output logic [ADDR_W-1:0] eMask, output logic [1:0] ePerm,
                       output bit eFault);
    int eff;
    logic [ADDR_W-1:0] idx, m;
    eff = (int'(cfgEntryCount) > DEPTH) ? DEPTH : int'(cfgEntryCount);
    idx = addr >> cfgPageShift;
    m = (ADDR_W'(1) << cfgPageShift) - 1;
    if (idx < ADDR_W'(eff)) begin
      eIova = addr & ~m; eXlat = shadow[idx[IDX_W-1:0]] & ~m; eMask = m;
      ePerm = shadow[idx[IDX_W-1:0]][1:0];
      eFault = (isWr && ePerm == 2'd1) || (!isWr && ePerm == 2'd2);
    end else begin
      eIova = '0; eXlat = '0; eMask = '1; ePerm = 2'd0; eFault = 1'b0;
    end
  endtask

  task automatic checkRsp(input string tag, input logic [ADDR_W-1:0] eIova,
                          input logic [ADDR_W-1:0] eXlat, input logic [ADDR_W-1:0] eMask,
                          input logic [1:0] ePerm, input bit eFault);
    chk({tag, " valid"}, 64'(rspValid), 64'd1);
    chk({tag, " iova"}, 64'(rspIova), 64'(eIova));
    chk({tag, " xlat"}, 64'(rspXlat), 64'(eXlat));
    chk({tag, " mask"}, 64'(rspMask), 64'(eMask));
    chk({tag, " perm"}, 64'(rspPerm), 64'(ePerm));
    chk({tag, " fault"}, 64'(rspFault), 64'(eFault));
  endtask

  // Issue one request, check response, drain it
  task automatic doReq(input string tag, input logic [ADDR_W-1:0] addr, input bit isWr);
    logic [ADDR_W-1:0] eIova, eXlat, eMask;
    logic [1:0] ePerm;
    bit eFault;
    model(addr, isWr, eIova, eXlat, eMask, ePerm, eFault);
    reqValid = 1'b1; reqAddr = addr; reqIsWrite = isWr;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    checkRsp(tag, eIova, eXlat, eMask, ePerm, eFault);
    rspReady = 1'b1;
    @(posedge clk); @(negedge clk);
    rspReady = 1'b0;
    chk({tag, " drained"}, 64'(rspValid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 reqReady", 64'(reqReady), 64'd1);
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 rspMask idle", 64'(rspMask), 64'd0);
  endtask

  task automatic t_basic();
    cfgPageShift = 5'd12; cfgEntryCount = 5'd16;
    for (int i = 0; i < DEPTH; i++)
      writeEntry(i, 32'h8000_0000 + (i << 12) + 32'h0000_0ab0 + (i % 4));
    doReq("R3 R4 R5 entry0", 32'h0000_0123, 1'b0);
    doReq("R3 R4 R5 entry5", 32'h0000_5fff, 1'b0);
    doReq("R3 R4 R5 entry15", 32'h0000_f004, 1'b1);
    doReq("R4 R5 entry3", 32'h0000_3800, 1'b1);
    chk("R11 window 16<<12", 64'(cfgWinSize), 64'h1_0000);
  endtask

  task automatic t_fault();
    doReq("R7 write readonly", 32'h0000_1010, 1'b1);
    doReq("R7 read writeonly", 32'h0000_2010, 1'b0);
    doReq("R7 read readonly", 32'h0000_1010, 1'b0);
    doReq("R7 write rw", 32'h0000_3010, 1'b1);
    doReq("R7 read none", 32'h0000_4010, 1'b0);
  endtask

  task automatic t_bounds();
    doReq("R6 index16 count16", 32'h0001_0000, 1'b0);
    cfgEntryCount = 5'd10;
    doReq("R3 index9 count10", 32'h0000_9abc, 1'b0);
    doReq("R6 index10 count10", 32'h0000_a000, 1'b1);
    doReq("R6 far address", 32'hffff_ffff, 1'b1);
    cfgEntryCount = 5'd20;
    doReq("R3 clamp count20 index15", 32'h0000_f000, 1'b0);
    doReq("R3 clamp count20 index16", 32'h0001_0000, 1'b0);
    chk("R11 clamped window", 64'(cfgWinSize), 64'h1_0000);
    cfgEntryCount = 5'd16;
  endtask

  task automatic t_disabled();
    cfgEntryCount = 5'd0;
    doReq("R8 disabled addr0", 32'h0000_0000, 1'b0);
    chk("R8 window zero", 64'(cfgWinSize), 64'd0);
    cfgEntryCount = 5'd16;
  endtask

  task automatic t_shift();
    cfgPageShift = 5'd8;
    doReq("R4 shift8", 32'h0000_0345, 1'b0);
    chk("R11 window 16<<8", 64'(cfgWinSize), 64'h1000);
    cfgPageShift = 5'd16;
    doReq("R4 shift16", 32'h0007_1234, 1'b1);
    cfgPageShift = 5'd12;
  endtask

  task automatic t_hold();
    logic [ADDR_W-1:0] eIova, eXlat, eMask;
    logic [1:0] ePerm;
    bit eFault;
    model(32'h0000_3456, 1'b0, eIova, eXlat, eMask, ePerm, eFault);
    reqValid = 1'b1; reqAddr = 32'h0000_3456; reqIsWrite = 1'b0;
    @(posedge clk); @(negedge clk);
    // keep a second request waiting, change config, rewrite entry 3
    reqAddr = 32'h0000_3678; reqIsWrite = 1'b1;
    cfgPageShift = 5'd16;
    tblWrEn = 1'b1; tblWrIdx = 4'd3; tblWrData = 32'h1234_5001;
    @(posedge clk); @(negedge clk);
    tblWrEn = 1'b0; shadow[3] = 32'h1234_5001;
    chk("R2 reqReady low while pending", 64'(reqReady), 64'd0);
    checkRsp("R9 R10 pending response held", eIova, eXlat, eMask, ePerm, eFault);
    cfgPageShift = 5'd12;
    rspReady = 1'b1;
    @(posedge clk); @(negedge clk);
    rspReady = 1'b0;
    chk("R2 drained", 64'(rspValid), 64'd0);
    chk("R2 ready again", 64'(reqReady), 64'd1);
    model(32'h0000_3678, 1'b1, eIova, eXlat, eMask, ePerm, eFault);
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R10 new entry visible", eIova, eXlat, eMask, ePerm, eFault);
    rspReady = 1'b1;
    @(posedge clk); @(negedge clk);
    rspReady = 1'b0;
    chk("R1 idle xlat zero", 64'(rspXlat), 64'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fault();
    t_bounds();
    t_disabled();
    t_shift();
    t_hold();
    finishRun();
  end

endmodule